// File: doc/BRIEF.md
# Modem Line Status Register with Sticky Change Flags

This block is the modem-status byte of a UART-style host register file. It watches four modem lines: carrier present, ringing, set ready and clear to send. The upper nibble of the byte shows the current level of each line. The lower nibble holds sticky flags that record changes on those lines since the host last read the byte.

A host read at the register's address returns the byte as it stood before the read. The read then clears the flags on the following clock edge. A change that lands on that same edge still sets its flag, so no event is lost. The interrupt output stays high while any flag is set.

When the loopback control bit is high, the status levels come from the modem-control output bits instead of the external pins. A level change caused by loopback is flagged in the same way as a change on a pin.

Top module: `modem_stat_reg`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is low.
- R2: Bits 7..4 hold the present levels in this order: bit 7 carrier, bit 6 ring, bit 5 set ready, bit 4 clear to send. A pin change shows up in these bits three clock edges after it is applied, because of two synchroniser stages and one status stage.
- R3: Bit 3 (carrier), bit 1 (set ready) and bit 0 (clear to send) are set by any level change of their line. Once set, they stay set until they are cleared.
- R4: Bit 2 is set only when the ring level goes from 1 to 0. A rising ring level leaves bit 2 unchanged.
- R5: A read at address 6 (`rd_en_i` high) returns the flags as they are before the read. Bits 3..0 are cleared on the clock edge that ends the read.
- R6: `irq_o` is high exactly while at least one of bits 3..0 is set.
- R7: With `mctl_i[4]`=1, the four levels come from the control bits. Carrier follows `mctl_i[3]`, ring follows `mctl_i[2]`, set ready follows `mctl_i[0]` and clear to send follows `mctl_i[1]`. The new levels appear one edge after the control bits change.
- R8: If a line change lands on the same edge as a read-clear, the flag for that change is set.
- R9: A level change caused by entering loopback, leaving loopback, or writing the control bits while in loopback sets the change flags exactly as a pin change would.
- R10: `rd_data_o` is 0x00 when `rd_en_i` is low or `rd_addr_i` is not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 1 | Carrier-present line, asynchronous |
| ring_i | input | 1 | Ringing line, asynchronous |
| setrdy_i | input | 1 | Set-ready line, asynchronous |
| clrsend_i | input | 1 | Clear-to-send line, asynchronous |
| mctl_i | input | 5 | Modem-control bits: [4] loopback, [3] aux2, [2] aux1, [1] request-send, [0] terminal-ready |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 3 | Host read address |
| rd_data_o | output | 8 | Read data: levels in [7:4], change flags in [3:0] |
| irq_o | output | 1 | Modem status interrupt |

## Verification
Directed patterns first raise the ring line alone and then drop it. This separates the trailing-edge flag from the any-edge flags of the other lines.

A read is then timed so that its clearing edge coincides with a new line change. This shows whether the set or the clear wins on that edge.

Loopback is driven with control words that make set ready and clear to send differ. A wrong bit mapping therefore shows up, and entering and leaving loopback is shown to raise flags. A long random mix of pin toggles, control writes and reads at scattered addresses is compared every cycle against a behavioural reference model.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int unsigned LINE_CNT    = 4;
    // line index inside each nibble (bit n of level and of delta)
    localparam int unsigned BIT_CLRSEND = 0;
    localparam int unsigned BIT_SETRDY  = 1;
    localparam int unsigned BIT_RING    = 2;
    localparam int unsigned BIT_CARRIER = 3;
    // modem-control bit positions
    localparam int unsigned CTL_W       = 5;
    localparam int unsigned CTL_TREADY  = 0;
    localparam int unsigned CTL_REQSEND = 1;
    localparam int unsigned CTL_AUX1    = 2;
    localparam int unsigned CTL_AUX2    = 3;
    localparam int unsigned CTL_LOOP    = 4;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t delta;
    } msr_state_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_mux.sv
module msr_src_mux
    import msr_pkg::*;
(
    input  line_vec_t        pin_lvl_i,
    input  logic [CTL_W-1:0] mctl_i,
    output line_vec_t        src_o
);
    always_comb begin
        if (mctl_i[CTL_LOOP]) begin
            src_o[BIT_CARRIER] = mctl_i[CTL_AUX2];
            src_o[BIT_RING]    = mctl_i[CTL_AUX1];
            src_o[BIT_SETRDY]  = mctl_i[CTL_TREADY];
            src_o[BIT_CLRSEND] = mctl_i[CTL_REQSEND];
        end else begin
            src_o = pin_lvl_i;
        end
    end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  line_vec_t  src_i,
    input  logic       clr_i,
    output msr_state_t state_o
);
    msr_state_t state_d, state_q;
    line_vec_t  set_d;

    always_comb begin
        set_d           = src_i ^ state_q.level;
        set_d[BIT_RING] = state_q.level[BIT_RING] & ~src_i[BIT_RING];
        state_d.level   = src_i;
        state_d.delta   = (clr_i ? '0 : state_q.delta) | set_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

    // any level change of carrier/set-ready/clear-send leaves its flag set
    p_edge_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.level[BIT_CARRIER] != $past(state_q.level[BIT_CARRIER]))
        |-> state_q.delta[BIT_CARRIER]);

    // a rising ring level never creates the ring flag
    p_ring_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(state_q.level[BIT_RING]) && !$past(state_q.delta[BIT_RING]))
        |-> !state_q.delta[BIT_RING]);

    // a clear with no coincident change empties the flags
    p_read_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clr_i) && state_q.level == $past(state_q.level))
        |-> state_q.delta == '0);

    // without a clear, flags are sticky
    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clr_i) |-> ((state_q.delta & $past(state_q.delta)) == $past(state_q.delta)));

    // change on the clearing edge still wins
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clr_i) && state_q.level[BIT_CLRSEND] != $past(state_q.level[BIT_CLRSEND]))
        |-> state_q.delta[BIT_CLRSEND]);
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
    import msr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned REG_ADDR    = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              carrier_i,
    input  logic              ring_i,
    input  logic              setrdy_i,
    input  logic              clrsend_i,
    input  logic [CTL_W-1:0]  mctl_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    line_vec_t  pin_raw, pin_sync, src_lvl;
    msr_state_t stat;
    logic       rd_hit;

    always_comb begin
        pin_raw              = '0;
        pin_raw[BIT_CARRIER] = carrier_i;
        pin_raw[BIT_RING]    = ring_i;
        pin_raw[BIT_SETRDY]  = setrdy_i;
        pin_raw[BIT_CLRSEND] = clrsend_i;
    end

    msr_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_raw),
        .sync_o  (pin_sync)
    );

    msr_src_mux mux_i (
        .pin_lvl_i (pin_sync),
        .mctl_i    (mctl_i),
        .src_o     (src_lvl)
    );

    assign rd_hit = rd_en_i && (rd_addr_i == HIT_ADDR);

    msr_delta delta_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_lvl),
        .clr_i   (rd_hit),
        .state_o (stat)
    );

    assign rd_data_o = rd_hit ? {stat.level, stat.delta} : 8'h00;
    assign irq_o     = |stat.delta;

    // interrupt agrees with the flags the host reads
    p_irq_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_hit |-> (irq_o == (rd_data_o[3:0] != 4'h0)));

    // loopback levels follow the control bits one edge later
    p_loop_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mctl_i[CTL_LOOP] |=>
            (stat.level[BIT_CARRIER] == $past(mctl_i[CTL_AUX2]))   &&
            (stat.level[BIT_RING]    == $past(mctl_i[CTL_AUX1]))   &&
            (stat.level[BIT_SETRDY]  == $past(mctl_i[CTL_TREADY])) &&
            (stat.level[BIT_CLRSEND] == $past(mctl_i[CTL_REQSEND])));
endmodule

// File: tb/modem_stat_reg_tb_top.sv
`timescale 1ns/1ps
module modem_stat_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier = 1'b0, ring = 1'b0, setrdy = 1'b0, clrsend = 1'b0;
    logic [4:0] mctl = 5'd0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modem_stat_reg dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .carrier_i(carrier), .ring_i(ring), .setrdy_i(setrdy), .clrsend_i(clrsend),
        .mctl_i(mctl), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // behavioural reference: levels {carrier,ring,setrdy,clrsend} as bits 3..0
    logic [3:0] sync_pipe[$];
    logic [3:0] m_lvl = 4'h0, m_dl = 4'h0;

    always @(posedge clk) begin
        logic [3:0] sel, set, synced;
        if (!rst_n) begin
            sync_pipe = '{4'h0, 4'h0};
            m_lvl = 4'h0;
            m_dl  = 4'h0;
        end else begin
            synced = sync_pipe[0];
            sel = mctl[4] ? {mctl[3], mctl[2], mctl[0], mctl[1]} : synced;
            set = sel ^ m_lvl;
            set[2] = m_lvl[2] && !sel[2];
            m_dl  = ((rd_en && rd_addr == 3'd6) ? 4'h0 : m_dl) | set;
            m_lvl = sel;
            void'(sync_pipe.pop_front());
            sync_pipe.push_back({carrier, ring, setrdy, clrsend});
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic hit;
            hit = rd_en && rd_addr == 3'd6;
            chk("R2 level", {4'h0, rd_data[7:4]}, hit ? {4'h0, m_lvl} : 8'h00);
            chk("R3 flags", {4'h0, rd_data[3:0]}, hit ? {4'h0, m_dl} : 8'h00);
            chk("R6 irq", {7'd0, irq}, {7'd0, m_dl != 4'h0});
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic host_read(string req, logic [7:0] exp, logic exp_irq);
        rd_addr = 3'd6;
        rd_en = 1'b1;
        #1;
        chk(req, rd_data, exp);
        chk(req, {7'd0, irq}, {7'd0, exp_irq});
        @(posedge clk);
        #2;
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: got hang expected finish");
        n_bad++;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        host_read("R1 reset", 8'h00, 1'b0);

        ring = 1'b1;                         // R4 rising ring: no flag
        tick(4);
        host_read("R4 rise", 8'h40, 1'b0);
        ring = 1'b0;                         // R4 falling ring: flag
        tick(4);
        host_read("R4 fall", 8'h04, 1'b1);
        host_read("R5 cleared", 8'h00, 1'b0);

        carrier = 1'b1;                      // R3 carrier edge
        tick(4);
        host_read("R3 carrier", 8'h88, 1'b1);
        host_read("R5 cleared", 8'h80, 1'b0);

        clrsend = 1'b1;                      // R8 change on clearing edge
        tick(2);
        host_read("R8 pre", 8'h80, 1'b0);
        host_read("R8 kept", 8'h91, 1'b1);
        host_read("R5 cleared", 8'h90, 1'b0);

        mctl = 5'b10000;                     // R9 enter loopback
        tick(1);
        host_read("R9 enter", 8'h09, 1'b1);
        host_read("R5 cleared", 8'h00, 1'b0);
        mctl = 5'b11111;
        tick(1);
        host_read("R7 all", 8'hFB, 1'b1);
        host_read("R5 cleared", 8'hF0, 1'b0);
        mctl = 5'b10100;
        tick(1);
        host_read("R7 ring", 8'h4B, 1'b1);
        mctl = 5'b10001;
        tick(1);
        host_read("R7 setrdy", 8'h26, 1'b1);
        mctl = 5'b00000;                     // R9 leave loopback
        tick(1);
        host_read("R9 leave", 8'h9B, 1'b1);

        rd_addr = 3'd2;                      // R10 other address
        rd_en = 1'b1;
        #1;
        chk("R10 addr", rd_data, 8'h00);
        tick(1);
        rd_en = 1'b0;
        #1;
        chk("R10 idle", rd_data, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            tick(1);
            if ($urandom % 6 == 0) begin
                case ($urandom % 4)
                    0: carrier = ~carrier;
                    1: ring    = ~ring;
                    2: setrdy  = ~setrdy;
                    default: clrsend = ~clrsend;
                endcase
            end
            if ($urandom % 24 == 0) mctl = 5'($urandom);
            rd_en = ($urandom % 4 == 0);
            rd_addr = ($urandom % 3 == 0) ? 3'($urandom) : 3'd6;
        end
        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule